// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Alignment Unit

This block is pure combinational logic. It sits between a word-wide data memory port and the register file of a big-endian integer core. For a load, the core supplies four things: the aligned word read from memory, the two low bits of the effective address, the current contents of the destination register and an access code. The unit returns the value to write back. That value may be a sign- or zero-extended byte or halfword, the whole word, or a partial-word merge. In a merge, part of the word overwrites the destination and the rest of the old register value is kept. For a store, the unit takes the source register value and produces memory write data with the narrow item copied into every lane, together with per-lane write enables.

Lane numbering is big-endian. Address offset 0 selects the most significant byte of the word (bits 31..24) and offset 3 selects the least significant byte. The effective address is the base register plus the displacement, unscaled, and it is computed outside this unit. Only its two low bits come in. Alignment faults are reported on a flag and are not acted on. The unit has no clock and no state, so every output follows its inputs in the same cycle. With no data path to stall, there is no handshake.

Top module: `be_ldst_align`

## Requirements
- R1: Access codes 0 (signed byte) and 1 (unsigned byte) return the byte at offset `addr_lo`. Offset 0 is bits 31..24 and offset 3 is bits 7..0. Code 0 sign-extends it to 32 bits and code 1 zero-extends it.
- R2: Access codes 2 (signed halfword) and 3 (unsigned halfword) return the halfword that starts at offset `{addr_lo[1],0}`. That is bits 31..16 when `addr_lo[1]` is 0 and bits 15..0 otherwise. Code 2 sign-extends it and code 3 zero-extends it.
- R3: Access code 4 (word load) returns `mem_rdata` unchanged for every offset.
- R4: Access code 5 (left merge) takes the 4−k bytes from offset k through offset 3 and places them in the top of the result. The low k bytes of the result come from `reg_in`. Offset 0 therefore gives the whole word and offset 3 replaces only bits 31..24.
- R5: Access code 6 (right merge) takes the k+1 bytes from offset 0 through offset k and places them in the bottom of the result. The upper 3−k bytes of the result come from `reg_in`. Offset 2 therefore writes three bytes and offset 3 gives the whole word.
- R6: Store codes produce the following `store_data`. Code 8 (byte) gives `reg_in[7:0]` in all four lanes. Code 9 (halfword) gives `reg_in[15:0]` in both halves. Code 10 (word) gives `reg_in`. All other codes give `reg_in`.
- R7: `byte_en[i]` enables bits 8i+7..8i. Code 8 sets only bit 3−k. Code 9 sets bits 3:2 when `addr_lo[1]` is 0 and bits 1:0 otherwise. Code 10 sets all four bits.
- R8: `misaligned` is 1 for codes 2, 3 and 9 when `addr_lo[0]` is 1, and for codes 4 and 10 when `addr_lo` is not 0. It is 0 for every other code and offset, which includes the byte codes and the two merge codes.
- R9: Every code that is not a store gives `byte_en` of 0. Codes 7 and 11 through 15 also return `reg_in` as `load_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_op | input | 4 | Access code (see R1–R9) |
| addr_lo | input | 2 | Low bits of the effective address |
| mem_rdata | input | 32 | Aligned word read from memory |
| reg_in | input | 32 | Old destination value for loads, source value for stores |
| load_data | output | 32 | Register write-back value |
| store_data | output | 32 | Lane-replicated memory write data |
| byte_en | output | 4 | Per-lane write enables, bit 3 = offset 0 |
| misaligned | output | 1 | Alignment fault indication |

## Verification
The bench sweeps every access code against every offset, using data whose sign bits are set in some patterns and clear in others. Under this sweep, a lane order reversed to little-endian shows up as wrong bytes at offsets 0 and 3. A swapped extension shows up as wrong upper bits on negative bytes and halfwords. A merge mask that is off by one lane either overwrites one old byte too many or keeps one too many. The offset-3 left merge and the offset-2 right merge are the sharpest probes of that mask. The bench also confirms that the merge codes never raise the fault flag and that the undefined codes drive no enables and return the old register value.

// File: rtl/be_ldst_pkg.sv
package be_ldst_pkg;
  localparam logic [3:0] OP_LDB   = 4'd0;
  localparam logic [3:0] OP_LDBU  = 4'd1;
  localparam logic [3:0] OP_LDH   = 4'd2;
  localparam logic [3:0] OP_LDHU  = 4'd3;
  localparam logic [3:0] OP_LDW   = 4'd4;
  localparam logic [3:0] OP_LDLFT = 4'd5;
  localparam logic [3:0] OP_LDRGT = 4'd6;
  localparam logic [3:0] OP_STB   = 4'd8;
  localparam logic [3:0] OP_STH   = 4'd9;
  localparam logic [3:0] OP_STW   = 4'd10;
endpackage

// File: rtl/be_ldst_load.sv
module be_ldst_load
  import be_ldst_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [3:0]                    acc_op,
  input  logic [$clog2(LANES)-1:0]      off,
  input  logic [LANES*BYTE_W-1:0]       mem_word,
  input  logic [LANES*BYTE_W-1:0]       old_word,
  output logic [LANES*BYTE_W-1:0]       result
);
  localparam int DW    = LANES * BYTE_W;
  localparam int HW    = 2 * BYTE_W;
  localparam int OFF_W = $clog2(LANES);

  logic [BYTE_W-1:0] mb [LANES];
  logic [BYTE_W-1:0] ob [LANES];

  // lane j is big-endian offset j: offset 0 lives in the top byte
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign mb[j] = mem_word[DW-1-j*BYTE_W -: BYTE_W];
    assign ob[j] = old_word[DW-1-j*BYTE_W -: BYTE_W];
  end

  logic [OFF_W-1:0]  h_off;
  logic [BYTE_W-1:0] sel_b;
  logic [HW-1:0]     sel_h;

  assign h_off = {off[OFF_W-1:1], 1'b0};
  assign sel_b = mb[off];
  assign sel_h = {mb[h_off], mb[h_off + OFF_W'(1)]};

  always_comb begin
    result = old_word;
    case (acc_op)
      OP_LDB:  result = {{(DW-BYTE_W){sel_b[BYTE_W-1]}}, sel_b};
      OP_LDBU: result = {{(DW-BYTE_W){1'b0}}, sel_b};
      OP_LDH:  result = {{(DW-HW){sel_h[HW-1]}}, sel_h};
      OP_LDHU: result = {{(DW-HW){1'b0}}, sel_h};
      OP_LDW:  result = mem_word;
      OP_LDLFT: begin
        for (int j = 0; j < LANES; j++) begin
          if (j + int'(off) < LANES)
            result[DW-1-j*BYTE_W -: BYTE_W] = mb[OFF_W'(j + int'(off))];
          else
            result[DW-1-j*BYTE_W -: BYTE_W] = ob[j];
        end
      end
      OP_LDRGT: begin
        for (int j = 0; j < LANES; j++) begin
          if (j >= LANES - 1 - int'(off))
            result[DW-1-j*BYTE_W -: BYTE_W] = mb[OFF_W'(j - (LANES - 1 - int'(off)))];
          else
            result[DW-1-j*BYTE_W -: BYTE_W] = ob[j];
        end
      end
      default: result = old_word;
    endcase
  end
endmodule

// File: rtl/be_ldst_store.sv
module be_ldst_store
  import be_ldst_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [3:0]                    acc_op,
  input  logic [$clog2(LANES)-1:0]      off,
  input  logic [LANES*BYTE_W-1:0]       src_word,
  output logic [LANES*BYTE_W-1:0]       wdata,
  output logic [LANES-1:0]              lane_en
);
  localparam int HW = 2 * BYTE_W;

  always_comb begin
    wdata   = src_word;
    lane_en = '0;
    case (acc_op)
      OP_STB: begin
        wdata = {LANES{src_word[BYTE_W-1:0]}};
        for (int j = 0; j < LANES; j++)
          lane_en[LANES-1-j] = (j == int'(off));
      end
      OP_STH: begin
        wdata = {(LANES/2){src_word[HW-1:0]}};
        for (int j = 0; j < LANES; j++)
          lane_en[LANES-1-j] = ((j / 2) == (int'(off) / 2));
      end
      OP_STW: begin
        wdata   = src_word;
        lane_en = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/be_ldst_misalign.sv
module be_ldst_misalign
  import be_ldst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [3:0]               acc_op,
  input  logic [$clog2(LANES)-1:0] off,
  output logic                     fault
);
  always_comb begin
    case (acc_op)
      OP_LDH, OP_LDHU, OP_STH: fault = off[0];
      OP_LDW, OP_STW:          fault = |off;
      default:                 fault = 1'b0;
    endcase
  end
endmodule

// File: rtl/be_ldst_align.sv
module be_ldst_align #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [3:0]                    acc_op,
  input  logic [$clog2(LANES)-1:0]      addr_lo,
  input  logic [LANES*BYTE_W-1:0]       mem_rdata,
  input  logic [LANES*BYTE_W-1:0]       reg_in,
  output logic [LANES*BYTE_W-1:0]       load_data,
  output logic [LANES*BYTE_W-1:0]       store_data,
  output logic [LANES-1:0]              byte_en,
  output logic                          misaligned
);
  be_ldst_load #(.LANES(LANES), .BYTE_W(BYTE_W)) u_load (
    .acc_op   (acc_op),
    .off      (addr_lo),
    .mem_word (mem_rdata),
    .old_word (reg_in),
    .result   (load_data)
  );

  be_ldst_store #(.LANES(LANES), .BYTE_W(BYTE_W)) u_store (
    .acc_op   (acc_op),
    .off      (addr_lo),
    .src_word (reg_in),
    .wdata    (store_data),
    .lane_en  (byte_en)
  );

  be_ldst_misalign #(.LANES(LANES)) u_mis (
    .acc_op (acc_op),
    .off    (addr_lo),
    .fault  (misaligned)
  );
endmodule

// File: rtl/be_ldst_align_chk.sv
module be_ldst_align_chk
  import be_ldst_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input logic [3:0]                    acc_op,
  input logic [$clog2(LANES)-1:0]      addr_lo,
  input logic [LANES*BYTE_W-1:0]       mem_rdata,
  input logic [LANES*BYTE_W-1:0]       reg_in,
  input logic [LANES*BYTE_W-1:0]       load_data,
  input logic [LANES*BYTE_W-1:0]       store_data,
  input logic [LANES-1:0]              byte_en,
  input logic                          misaligned
);
  localparam int DW = LANES * BYTE_W;

  logic is_store;
  assign is_store = (acc_op == OP_STB) || (acc_op == OP_STH) || (acc_op == OP_STW);

  always_comb begin
    if (acc_op == OP_LDB)
      p_sext_byte_r1: assert (load_data[DW-1:BYTE_W] == {(DW-BYTE_W){load_data[BYTE_W-1]}});
    if (acc_op == OP_LDW && addr_lo == '0)
      p_word_pass_r3: assert (load_data == mem_rdata);
    if (acc_op == OP_LDLFT && addr_lo == '0)
      p_left_full_r4: assert (load_data == mem_rdata);
    if (acc_op == OP_LDRGT && addr_lo == '1)
      p_right_full_r5: assert (load_data == mem_rdata);
    if (acc_op == OP_STB)
      p_one_lane_r7: assert ($onehot(byte_en));
    if (acc_op == OP_STW)
      p_all_lanes_r7: assert (&byte_en);
    if (acc_op == OP_LDLFT || acc_op == OP_LDRGT || acc_op == OP_LDB || acc_op == OP_LDBU)
      p_no_fault_r8: assert (!misaligned);
    if (!is_store)
      p_no_enable_r9: assert (byte_en == '0);
    if (is_store)
      p_en_count_r7: assert ($countones(byte_en) inside {1, 2, LANES});
  end
endmodule

bind be_ldst_align be_ldst_align_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/be_ldst_align_bench.sv
module be_ldst_align_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  acc_op = '0;
  logic [1:0]  addr_lo = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] reg_in = '0;
  logic [31:0] load_data, store_data;
  logic [3:0]  byte_en;
  logic        misaligned;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  be_ldst_align u_be_ldst_align (
    .acc_op(acc_op), .addr_lo(addr_lo), .mem_rdata(mem_rdata), .reg_in(reg_in),
    .load_data(load_data), .store_data(store_data), .byte_en(byte_en),
    .misaligned(misaligned)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d off=%0d actual=%h expected=%h", tag, acc_op, addr_lo, act, exp);
    end
  endtask

  // behavioural reference, written from the requirements
  task automatic model(input int op, input int k, input logic [31:0] m, input logic [31:0] r,
                       output logic [31:0] ld, output logic [31:0] sd,
                       output logic [3:0] be, output logic mis, output string tag);
    logic [63:0] w;
    logic [7:0]  b;
    logic [15:0] h;
    int n;
    b = 8'((m >> (8 * (3 - k))) & 32'hFF);
    h = 16'((m >> (16 * (1 - k / 2))) & 32'hFFFF);
    ld = r; sd = r; be = 4'b0000; mis = 1'b0; tag = "R9";
    case (op)
      0: begin ld = {{24{b[7]}}, b}; tag = "R1"; end
      1: begin ld = {24'h0, b}; tag = "R1"; end
      2: begin ld = {{16{h[15]}}, h}; mis = (k % 2) != 0; tag = "R2"; end
      3: begin ld = {16'h0, h}; mis = (k % 2) != 0; tag = "R2"; end
      4: begin ld = m; mis = (k != 0); tag = "R3"; end
      5: begin
        n = 8 * k;
        w = ({32'h0, m} << n) | ({32'h0, r} & ((64'h1 << n) - 64'h1));
        ld = w[31:0]; tag = "R4";
      end
      6: begin
        n = 8 * (3 - k);
        ld = (m >> n) | (r & ~(32'hFFFF_FFFF >> n)); tag = "R5";
      end
      8: begin sd = {4{r[7:0]}}; be = 4'(1 << (3 - k)); tag = "R6"; end
      9: begin sd = {2{r[15:0]}}; be = (k < 2) ? 4'b1100 : 4'b0011; mis = (k % 2) != 0; tag = "R6"; end
      10: begin sd = r; be = 4'b1111; mis = (k != 0); tag = "R6"; end
      default: ;
    endcase
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] e_ld, e_sd;
    logic [3:0]  e_be;
    logic        e_mis;
    string       tag;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: code 0 with zero data, then an undefined code
    @(negedge clk);
    #1;
    chk("R1 idle load", load_data, 32'h0);
    chk("R9 idle enables", {28'h0, byte_en}, 32'h0);
    acc_op = 4'd15; reg_in = 32'hCAFE_F00D;
    #1;
    chk("R9 undefined code keeps reg", load_data, 32'hCAFE_F00D);
    // directed corners: left merge offset 3, right merge offset 2
    @(negedge clk);
    acc_op = 4'd5; addr_lo = 2'd3; mem_rdata = 32'hA1B2C3D4; reg_in = 32'h11223344;
    #1;
    chk("R4 left merge offset 3 one byte", load_data, 32'hD4223344);
    acc_op = 4'd6; addr_lo = 2'd2;
    #1;
    chk("R5 right merge offset 2 three bytes", load_data, 32'h11A1B2C3);
    // sweep every code, offset and data pattern
    for (int p = 0; p < 6; p++) begin
      for (int op = 0; op < 16; op++) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          acc_op    = 4'(op);
          addr_lo   = 2'(k);
          mem_rdata = 32'h8172_E3D4 ^ (32'(p) * 32'h1F3E_5D7C);
          reg_in    = 32'h5A6B_F788 ^ (32'(p) * 32'h9E37_79B9);
          #1;
          model(op, k, mem_rdata, reg_in, e_ld, e_sd, e_be, e_mis, tag);
          if (op < 8 || op > 10) chk({tag, " load_data"}, load_data, e_ld);
          if (op >= 8 && op <= 10) chk("R6 store_data", store_data, e_sd);
          chk("R7 byte_en", {28'h0, byte_en}, {28'h0, e_be});
          chk("R8 misaligned", {31'h0, misaligned}, {31'h0, e_mis});
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule